// File: doc/BRIEF.md
# E1 Receive Spare-Bit Stack

This block sits behind an E1 receive framer. It gathers the five spare bits (Sa4 to Sa8) carried in the odd-numbered (non-alignment) frames. Over one 32-frame double multiframe it collects 16 values of each spare bit. At the end of that window it copies the whole set at once into ten byte-wide registers that a host can read, and it raises a ready flag. Reading the status register clears the flag.

With CRC-4 framing enabled, the framer's frame number sets the window, so the boundary follows the received multiframe. With CRC-4 disabled, a free-running strobe counter sets the window, and its phase has no meaning. While alignment is lost, collection and publishing stop and the interrupt is held low. After recovery, a complete new double multiframe must be gathered before the host view changes again. A new set replaces the previous one whether or not the host has read it.

Top module: `e1_rx_spare_stack`

## Requirements
- R1: Stack address 2s+h (s = 0..4 for Sa4..Sa8, h = 0 or 1) holds the values of sa_rx[s] for frame slots k = 8h..8h+7, where slot k is frame 2k+1. Slot k sits in bit 7-(k mod 8), so frame 1 is in bit 7 of address 0 and frame 31 is in bit 0 of address 9. Even frames are never captured.
- R2: The readable stack changes only at the clock edge that publishes, and it takes the complete new set at that edge. A read between publishes returns the previously published values.
- R3: Address 10 is status: bit 0 is the ready flag, bit 1 is the current halt state, and the other bits are 0. Reading it returns the value held before the read and clears ready, unless a publish happens in the same cycle. Addresses 11 to 15 read 0. rd_data is registered and valid in the cycle after rd_en.
- R4: With crc4_en = 1, the frame position is frm_num, and a publish occurs on the strobe with frm_num = 31.
- R5: With crc4_en = 0, frm_num is ignored. The frame position is the number of strobes since reset modulo 32, so the first strobe after reset is position 0.
- R6: A publish overwrites the readable stack and sets ready even if the previous set was never read.
- R7: Halt is lmfa when crc4_en = 1 and lfa when crc4_en = 0; the other indication has no effect. A strobe taken while halted is neither captured nor published.
- R8: After a halt, or after any change of crc4_en, the partial collection is discarded. The next publish needs a strobe at position 0 taken while not halted, followed by the strobe at position 31.
- R9: irq is registered and equals ready AND irq_en AND NOT halt, as sampled at the same edge.
- R10: After reset, every stack address and the status read 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_stb | input | 1 | One-cycle strobe per received frame |
| frm_num | input | 5 | Frame number within the CRC-4 double multiframe |
| sa_rx | input | 5 | Received spare bits, bit 0 = Sa4 ... bit 4 = Sa8 |
| crc4_en | input | 1 | CRC-4 framing mode enable |
| lfa | input | 1 | Loss of frame alignment |
| lmfa | input | 1 | Loss of CRC-4 multiframe alignment |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 4 | Host read address |
| rd_data | output | 8 | Registered read data |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Stack-ready interrupt |

## Verification
The bench reads the stack one frame before the boundary. A design that copied bits into the host view as they arrived would show new data there. It also recovers from alignment loss in the middle of a multiframe. A design that did not discard the partial buffer would publish a set mixing stale and fresh bits, or publish one boundary too early. Other cases are a mode switch that must restart collection, the alignment indication that belongs to the other mode, which must be ignored, and back-to-back publishes with no status read in between. In the counter-driven mode, garbage frame numbers expose a design that still decodes frm_num.

// File: rtl/e1sa_pkg.sv
package e1sa_pkg;
  // collection tracker: halted, waiting for a window start, collecting a window
  typedef enum logic [1:0] {TRK_HOLD, TRK_SYNC, TRK_RUN} trk_state_t;
  localparam int STAT_READY_BIT = 0;
  localparam int STAT_HALT_BIT  = 1;
endpackage

// File: rtl/e1sa_frame_track.sv
module e1sa_frame_track
  import e1sa_pkg::*;
#(
  parameter int FRAMES = 32,
  localparam int FW = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_i,
  input  logic [FW-1:0] frm_i,
  input  logic          crc4_i,
  input  logic          lfa_i,
  input  logic          lmfa_i,
  output logic          halt_o,
  output logic [FW-1:0] pos_o,
  output logic          wr_o,
  output logic          clr_o,
  output logic          pub_o
);
  localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

  logic [FW-1:0] cnt_q;
  logic          crc_q;
  logic          mode_chg;
  trk_state_t    st_q, st_d;

  always_comb begin
    halt_o   = crc4_i ? lmfa_i : lfa_i;
    mode_chg = crc4_i != crc_q;
    pos_o    = crc4_i ? frm_i : cnt_q;
    clr_o    = halt_o | mode_chg;
    wr_o     = stb_i & ~clr_o & pos_o[0];
    pub_o    = stb_i & ~clr_o & (st_q == TRK_RUN) & (pos_o == LAST);
  end

  always_comb begin
    st_d = st_q;
    if (halt_o)                    st_d = TRK_HOLD;
    else if (mode_chg)             st_d = TRK_SYNC;
    else if (stb_i && pos_o == '0) st_d = TRK_RUN;
    else if (st_q == TRK_HOLD)     st_d = TRK_SYNC;
  end

  always_ff @(posedge clk) begin
    crc_q <= crc4_i;
    if (rst) begin
      cnt_q <= '0;
      st_q  <= TRK_SYNC;
    end else begin
      st_q <= st_d;
      if (stb_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // R7: a halted strobe neither writes the capture buffer nor publishes
  a_r7_halt_blocks: assert property (@(posedge clk) disable iff (rst)
    halt_o |-> (!wr_o && !pub_o));
  // R4: publishing only ever happens at the last frame position
  a_r4_pub_at_last: assert property (@(posedge clk) disable iff (rst)
    pub_o |-> (pos_o == LAST));
  // R8: the cycle after a discard can never publish
  a_r8_no_pub_after_discard: assert property (@(posedge clk) disable iff (rst)
    clr_o |=> !pub_o);
endmodule

// File: rtl/e1sa_capture.sv
module e1sa_capture #(
  parameter int NUM_SA = 5,
  parameter int FRAMES = 32,
  parameter int BYTE_W = 8,
  localparam int FW        = $clog2(FRAMES),
  localparam int SLOTS     = FRAMES / 2,
  localparam int BYTES_PER = SLOTS / BYTE_W,
  localparam int NBITS     = NUM_SA * SLOTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              clr_i,
  input  logic [FW-1:0]     pos_i,
  input  logic [NUM_SA-1:0] sa_i,
  output logic [NBITS-1:0]  snap_o
);
  logic [NBITS-1:0] cap_q;
  logic [NBITS-1:0] merged;

  // every bit of the flat image is owned by exactly one (spare bit, slot) pair
  for (genvar gs = 0; gs < NUM_SA; gs++) begin : g_sa
    for (genvar gk = 0; gk < SLOTS; gk++) begin : g_slot
      localparam int BI = (gs * BYTES_PER + gk / BYTE_W) * BYTE_W + (BYTE_W - 1 - gk % BYTE_W);
      localparam logic [FW-1:0] FP = FW'(2 * gk + 1);
      assign merged[BI] = (wr_i && pos_i == FP) ? sa_i[gs] : cap_q[BI];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) cap_q <= '0;
    else if (wr_i)    cap_q <= merged;
  end

  // the publish path sees the buffer with the current frame's bit already in place
  assign snap_o = merged;

  // R8: a discard leaves an empty buffer behind
  a_r8_discard_empties: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !wr_i) |=> (cap_q == '0));
endmodule

// File: rtl/e1sa_host_view.sv
module e1sa_host_view
  import e1sa_pkg::*;
#(
  parameter int NREG   = 10,
  parameter int BYTE_W = 8,
  localparam int AW    = $clog2(NREG + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pub_i,
  input  logic [NREG*BYTE_W-1:0] snap_i,
  input  logic                   halt_i,
  input  logic                   rd_en_i,
  input  logic [AW-1:0]          rd_addr_i,
  input  logic                   irq_en_i,
  output logic [BYTE_W-1:0]      rd_data_o,
  output logic                   irq_o
);
  localparam logic [AW-1:0] STAT_ADDR = AW'(NREG);

  logic [BYTE_W-1:0]      pub_q [NREG];
  logic [NREG*BYTE_W-1:0] pub_flat;
  logic                   rdy_q, rdy_d;
  logic                   stat_rd;
  logic [BYTE_W-1:0]      stat_b, rd_d;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_flat
    assign pub_flat[gi*BYTE_W +: BYTE_W] = pub_q[gi];
  end

  always_comb begin
    stat_rd                = rd_en_i && (rd_addr_i == STAT_ADDR);
    stat_b                 = '0;
    stat_b[STAT_READY_BIT] = rdy_q;
    stat_b[STAT_HALT_BIT]  = halt_i;
    if (rd_addr_i < STAT_ADDR)       rd_d = pub_q[rd_addr_i];
    else if (rd_addr_i == STAT_ADDR) rd_d = stat_b;
    else                             rd_d = '0;
    if (pub_i)        rdy_d = 1'b1;
    else if (stat_rd) rdy_d = 1'b0;
    else              rdy_d = rdy_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) pub_q[i] <= '0;
      rdy_q     <= 1'b0;
      irq_o     <= 1'b0;
      rd_data_o <= '0;
    end else begin
      if (pub_i)
        for (int i = 0; i < NREG; i++) pub_q[i] <= snap_i[i*BYTE_W +: BYTE_W];
      rdy_q <= rdy_d;
      irq_o <= rdy_d & irq_en_i & ~halt_i;
      if (rd_en_i) rd_data_o <= rd_d;
    end
  end

  // R2: the host view holds still between publishes
  a_r2_view_stable: assert property (@(posedge clk) disable iff (rst)
    !pub_i |=> $stable(pub_flat));
  // R3: a status read with no concurrent publish leaves ready low
  a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !pub_i) |=> !rdy_q);
  // R6: ready only rises through a publish
  a_r6_ready_from_pub: assert property (@(posedge clk) disable iff (rst)
    (!rdy_q && !pub_i) |=> !rdy_q);
  // R9: the interrupt is low after any halted cycle
  a_r9_irq_quiet_halt: assert property (@(posedge clk) disable iff (rst)
    halt_i |=> !irq_o);
endmodule

// File: rtl/e1_rx_spare_stack.sv
module e1_rx_spare_stack #(
  parameter int NUM_SA = 5,
  parameter int FRAMES = 32,
  parameter int BYTE_W = 8,
  localparam int FW        = $clog2(FRAMES),
  localparam int SLOTS     = FRAMES / 2,
  localparam int BYTES_PER = SLOTS / BYTE_W,
  localparam int NREG      = NUM_SA * BYTES_PER,
  localparam int AW        = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_stb,
  input  logic [FW-1:0]     frm_num,
  input  logic [NUM_SA-1:0] sa_rx,
  input  logic              crc4_en,
  input  logic              lfa,
  input  logic              lmfa,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              irq_en,
  output logic              irq
);
  logic                   halt, wr, clr, pub;
  logic [FW-1:0]          pos;
  logic [NREG*BYTE_W-1:0] snap;

  e1sa_frame_track #(.FRAMES(FRAMES)) u_track (
    .clk(clk), .rst(rst), .stb_i(frm_stb), .frm_i(frm_num), .crc4_i(crc4_en),
    .lfa_i(lfa), .lmfa_i(lmfa), .halt_o(halt), .pos_o(pos), .wr_o(wr),
    .clr_o(clr), .pub_o(pub)
  );

  e1sa_capture #(.NUM_SA(NUM_SA), .FRAMES(FRAMES), .BYTE_W(BYTE_W)) u_cap (
    .clk(clk), .rst(rst), .wr_i(wr), .clr_i(clr), .pos_i(pos), .sa_i(sa_rx),
    .snap_o(snap)
  );

  e1sa_host_view #(.NREG(NREG), .BYTE_W(BYTE_W)) u_host (
    .clk(clk), .rst(rst), .pub_i(pub), .snap_i(snap), .halt_i(halt),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .irq_en_i(irq_en),
    .rd_data_o(rd_data), .irq_o(irq)
  );
endmodule

// File: tb/test_e1_rx_spare_stack.sv
`timescale 1ns/1ps
module test_e1_rx_spare_stack;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frm_stb = 1'b0;
  logic [4:0] frm_num = '0;
  logic [4:0] sa_rx = '0;
  logic       crc4_en = 1'b1;
  logic       lfa = 1'b0;
  logic       lmfa = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq_en = 1'b0;
  logic       irq;

  always #2.5 clk = ~clk;

  e1_rx_spare_stack i_e1_rx_spare_stack (
    .clk(clk), .rst(rst), .frm_stb(frm_stb), .frm_num(frm_num), .sa_rx(sa_rx),
    .crc4_en(crc4_en), .lfa(lfa), .lmfa(lmfa), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_en(irq_en), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit m_crc = 1, m_lfa = 0, m_lmfa = 0, m_ien = 0, prev_crc = 1;
  bit [7:0] mcap [10];
  bit [7:0] mpub [10];
  bit armed = 0, ready = 0;
  int cnt = 0;

  function automatic bit cur_halt();
    return m_crc ? m_lmfa : m_lfa;
  endfunction

  function automatic int byte_of(int s, int k);
    return 2 * s + k / 8;
  endfunction

  function automatic int bit_of(int k);
    return 7 - (k % 8);
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_frame(int fn, bit [4:0] sa);
    bit h = cur_halt();
    int pos = m_crc ? fn : cnt;
    bit chg = (m_crc != prev_crc);
    cnt = (cnt + 1) % 32;
    prev_crc = m_crc;
    if (h || chg) begin
      armed = 0;
      foreach (mcap[i]) mcap[i] = 8'h00;
    end else begin
      if (pos % 2 == 1)
        for (int s = 0; s < 5; s++) mcap[byte_of(s, pos / 2)][bit_of(pos / 2)] = sa[s];
      if (pos == 0) armed = 1;
      else if (pos == 31 && armed) begin
        foreach (mpub[i]) mpub[i] = mcap[i];
        ready = 1;
      end
    end
  endtask

  task automatic frame(int fn, bit [4:0] sa, int gap);
    @(negedge clk);
    frm_stb = 1; frm_num = 5'(fn); sa_rx = sa;
    crc4_en = m_crc; lfa = m_lfa; lmfa = m_lmfa; irq_en = m_ien;
    @(posedge clk);
    model_frame(fn, sa);
    @(negedge clk);
    frm_stb = 0;
    chk("R9", int'(irq), int'(ready & m_ien & ~cur_halt()), "irq after frame");
    repeat (gap) @(negedge clk);
  endtask

  task automatic rd(int addr, string req);
    int exp;
    @(negedge clk);
    rd_en = 1; rd_addr = 4'(addr);
    @(posedge clk);
    if (addr < 10) exp = mpub[addr];
    else if (addr == 10) begin
      exp = {cur_halt(), ready};
      ready = 0;
    end else exp = 0;
    @(negedge clk);
    rd_en = 0;
    chk(req, int'(rd_data), exp, $sformatf("read addr %0d", addr));
    chk("R9", int'(irq), int'(ready & m_ien & ~cur_halt()), "irq after read");
  endtask

  task automatic rd_all(string req);
    for (int a = 0; a < 10; a++) rd(a, req);
  endtask

  task automatic mframe_rand(int gapmax);
    for (int f = 0; f < 32; f++) frame(f, 5'($urandom), int'($urandom_range(gapmax, 0)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    foreach (mcap[i]) begin mcap[i] = 0; mpub[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;

    // R10: reset state
    for (int a = 0; a < 16; a++) rd(a, "R10");
    chk("R10", int'(irq), 0, "irq after reset");

    // R4/R1: two random CRC-4 windows, mid-window read before the boundary (R2)
    mframe_rand(2);
    rd_all("R1");
    rd(10, "R3");
    rd(10, "R3");
    for (int f = 0; f < 31; f++) frame(f, 5'($urandom), 0);
    rd(0, "R2");
    rd(9, "R2");
    frame(31, 5'($urandom), 0);
    rd_all("R4");
    rd(10, "R3");
    rd(12, "R3");

    // R1 directed: only frame 1 Sa4 and frame 31 Sa8 set
    for (int f = 0; f < 32; f++) frame(f, (f == 1) ? 5'b00001 : (f == 31) ? 5'b10000 : (f % 2 == 0) ? 5'b11111 : 5'b0, 0);
    rd(0, "R1");
    rd(9, "R1");
    chk("R1", int'(mpub[0]), 8'h80, "model frame 1 position");
    rd_all("R1");

    // R6/R9: two publishes with no status read, interrupt enabled
    m_ien = 1;
    mframe_rand(1);
    mframe_rand(1);
    rd_all("R6");
    rd(10, "R6");
    rd(10, "R9");

    // R7/R8: CRC-4 halt mid-window with lfa wiggling
    mframe_rand(0);
    for (int f = 0; f < 8; f++) frame(f, 5'($urandom), 0);
    m_lfa = 1;
    for (int f = 8; f < 11; f++) frame(f, 5'($urandom), 0);
    m_lmfa = 1;
    for (int f = 11; f < 16; f++) frame(f, 5'($urandom), 1);
    rd(10, "R7");
    m_lmfa = 0; m_lfa = 0;
    for (int f = 16; f < 32; f++) frame(f, 5'($urandom), 0);
    rd(10, "R8");
    rd_all("R8");
    mframe_rand(0);
    rd_all("R8");
    rd(10, "R8");

    // R5: counter mode with garbage frame numbers; mode switch restarts (R8)
    m_crc = 0;
    for (int i = 0; i < 80; i++) frame(int'($urandom_range(31, 0)), 5'($urandom), 0);
    rd_all("R5");
    rd(10, "R5");
    m_lmfa = 1;
    for (int i = 0; i < 20; i++) frame(int'($urandom_range(31, 0)), 5'($urandom), 0);
    m_lfa = 1;
    for (int i = 0; i < 10; i++) frame(int'($urandom_range(31, 0)), 5'($urandom), 0);
    rd(10, "R7");
    m_lfa = 0; m_lmfa = 0;
    for (int i = 0; i < 70; i++) frame(int'($urandom_range(31, 0)), 5'($urandom), 0);
    rd_all("R5");
    rd(10, "R5");

    // constrained random mix
    begin
      int fn = 0;
      for (int i = 0; i < 600; i++) begin
        if ($urandom_range(99, 0) < 2) m_crc = ~m_crc;
        if ($urandom_range(99, 0) < 3) m_lfa = ~m_lfa;
        if ($urandom_range(99, 0) < 3) m_lmfa = ~m_lmfa;
        if ($urandom_range(99, 0) < 5) m_ien = ~m_ien;
        fn = ($urandom_range(99, 0) < 3) ? int'($urandom_range(31, 0)) : (fn + 1) % 32;
        frame(fn, 5'($urandom), int'($urandom_range(1, 0)));
        if ($urandom_range(99, 0) < 10) rd(int'($urandom_range(15, 0)), "R2");
      end
    end
    rd_all("R2");
    rd(10, "R3");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule